// File: doc/BRIEF.md
# Shared Forward/Inverse Radix-4 Modular Butterfly

This block computes one radix-4 butterfly over four 12-bit coefficients modulo q = 3329 and accepts a new operand set on every clock. A mode input chooses the forward transform step (twiddles applied before the add/subtract network) or the inverse step (twiddles applied after it). One bank of three twiddle multipliers, two add/subtract layers and one constant multiplier serve both directions. The constant multiplier applies the primitive fourth root of unity 1729 in forward mode and its inverse 1600 in inverse mode. Every product is brought back into range by a split-halves folding reduction. The fold uses 2^12 ≡ 767 (mod q).

The block sits inside a fully unrolled transform array. It takes its twiddles from that array, which also wires its lanes to the neighbouring butterflies. For the last inverse layer the caller asserts a final flag and supplies twiddles that were already multiplied by 3303, the inverse of 128 mod q. The block then multiplies only the twiddle-free output by 3303. This gives the whole 1/128 scaling with a single extra multiplier.

Top module: `rad4_butterfly`

## Requirements
- R1: While `rst` is high, and until five clock edges after it falls, `outValid` stays low. Operand sets presented while `rst` is high produce no result.
- R2: An operand set sampled with `inValid` high at a rising edge appears with `outValid` high exactly five rising edges later. Sets may arrive on consecutive cycles, and results leave in arrival order.
- R3: With `inMode` = 0 (forward), let lane k of `inCoef` be a_k and lane k of `inTw` be w_k. Form p1=a1·w0, p2=a2·w1 and p3=a3·w2. Then s=a0+p2, d=a0−p2, t=p1+p3 and e=1729·(p1−p3). The outputs in lane order are s+t, s−t, d+e and d−e, all mod 3329.
- R4: With `inMode` = 1 (inverse), form s=a0+a1, d=a0−a1, t=a2+a3 and e=1600·(a2−a3). The outputs in lane order are s+t, w0·(d+e), w1·(s−t) and w2·(d−e), all mod 3329.
- R5: In forward mode with twiddles (w1, w0, w0·w1), the outputs equal two cascaded decimation-in-time radix-2 stages. The first stage pairs lanes (0,2) and (1,3) under w0. The second pairs (0,1) under w1 and (2,3) under 1729·w1.
- R6: In inverse mode with twiddles (v1, v0, v0·v1), the outputs equal two cascaded decimation-in-frequency radix-2 stages. The first stage pairs lanes (0,1) under v1 and (2,3) under 1600·v1. The second pairs (0,2) and (1,3) under v0.
- R7: With `inMode` = 1 and `inFinal` = 1, output lane 0 is the R4 value times 3303. When the three twiddles are premultiplied by 3303, all four outputs equal the plain R4 result times 3303.
- R8: In forward mode `inFinal` has no effect on the outputs.
- R9: For inputs in 0..3328, every output lane lies in 0..3328, including inputs of 0 and 3328.
- R10: A cycle with `inValid` low produces no result, and its data lines do not disturb the results of neighbouring sets.
- R11: After the pipeline has drained, the mode may change, and the next sets follow the new mode's rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand set present this cycle |
| inMode | input | 1 | 0 forward step, 1 inverse step |
| inFinal | input | 1 | Last inverse layer: scale lane 0 by 3303 |
| inCoef | input | 48 | Four coefficients, lane k in bits 12k+11:12k |
| inTw | input | 36 | Three twiddles, lane k in bits 12k+11:12k |
| outValid | output | 1 | Result present this cycle |
| outCoef | output | 48 | Four reduced results, same lane packing |

## Verification
The twiddle multipliers are shared between the first stage (forward) and the fourth stage (inverse). The assertions therefore assume that no operand set enters with a mode different from any valid set still in flight. They also assume that all coefficient and twiddle inputs are already reduced below 3329. The stimulus keeps to this by drawing every value from 0..3328 and by idling the pipeline for several cycles before each change of direction. Idle cycles carry random junk on the data lines and in the final flag, but never a mode change while sets are in flight.

// File: rtl/rad4_pkg.sv
package rad4_pkg;

  localparam int COEF_W     = 12;
  localparam int PROD_W     = 2 * COEF_W;
  localparam int MODQ       = 3329;
  localparam int FOLD_K     = (1 << COEF_W) - MODQ;   // 2^12 mod q
  localparam int FOLD_STEPS = 6;
  localparam int LANES      = 4;
  localparam int TWIDS      = LANES - 1;
  localparam int PIPE_DEPTH = 5;
  localparam int ROOT_GEN   = 17;
  localparam int ROOT_ORDER = 256;
  localparam int NTT_POINTS = 128;

  function automatic int powMod(input int base, input int expo);
    int res;
    int sq;
    res = 1;
    sq  = base % MODQ;
    for (int i = 0; i < 16; i++) begin
      if (expo[i]) res = (res * sq) % MODQ;
      sq = (sq * sq) % MODQ;
    end
    return res;
  endfunction

  localparam int QUARTER_ROOT = powMod(ROOT_GEN, ROOT_ORDER / 4);   // 1729
  localparam int QUARTER_INV  = MODQ - QUARTER_ROOT;                // 1600
  localparam int INV_SCALE    = powMod(NTT_POINTS, MODQ - 2);       // 3303

  typedef logic [COEF_W-1:0]  coef_t;
  typedef coef_t [LANES-1:0]  quad_t;
  typedef coef_t [TWIDS-1:0]  twid_t;

  typedef struct packed {
    logic [PIPE_DEPTH-1:0] load;   // register enable per stage
    logic inv0;                    // mode of the set entering stage 1
    logic inv1;
    logic inv2;
    logic inv3;
    logic inv4;
    logic mulLate;                 // twiddle bank fed from stage 4
    logic scaleY0;                 // lane 0 takes the 1/128 factor
  } strobe_t;

  function automatic coef_t reduceProd(input logic [PROD_W-1:0] x);
    logic [PROD_W-1:0] acc;
    acc = x;
    for (int i = 0; i < FOLD_STEPS; i++) begin
      acc = PROD_W'(acc[PROD_W-1:COEF_W]) * PROD_W'(FOLD_K)
          + PROD_W'(acc[COEF_W-1:0]);
    end
    if (acc >= PROD_W'(MODQ)) acc = acc - PROD_W'(MODQ);
    return acc[COEF_W-1:0];
  endfunction

  function automatic coef_t modAdd(input coef_t a, input coef_t b);
    logic [COEF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (COEF_W+1)'(MODQ)) s = s - (COEF_W+1)'(MODQ);
    return s[COEF_W-1:0];
  endfunction

  function automatic coef_t modSub(input coef_t a, input coef_t b);
    logic [COEF_W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + (COEF_W+1)'(MODQ) - {1'b0, b};
    return s[COEF_W-1:0];
  endfunction

endpackage

// File: rtl/rad4_modmul.sv
module rad4_modmul
  import rad4_pkg::*;
(
  input  coef_t opA,
  input  coef_t opB,
  output coef_t prod
);

  logic [PROD_W-1:0] fullProd;

  assign fullProd = PROD_W'(opA) * PROD_W'(opB);
  assign prod     = reduceProd(fullProd);

endmodule

// File: rtl/rad4_ctrl.sv
module rad4_ctrl
  import rad4_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    inMode,
  input  logic    inFinal,
  output strobe_t stb,
  output logic    outValid
);

  localparam int WARM_W = $clog2(PIPE_DEPTH + 1);

  logic [PIPE_DEPTH:1]   vld;
  logic [PIPE_DEPTH-1:1] invMode;
  logic [PIPE_DEPTH-1:1] finFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      invMode <= '0;
      finFlag <= '0;
    end else begin
      vld     <= {vld[PIPE_DEPTH-1:1], inValid};
      invMode <= {invMode[PIPE_DEPTH-2:1], inMode};
      finFlag <= {finFlag[PIPE_DEPTH-2:1], inFinal};
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = {vld[PIPE_DEPTH-1:1], inValid};
    stb.inv0    = inMode;
    stb.inv1    = invMode[1];
    stb.inv2    = invMode[2];
    stb.inv3    = invMode[3];
    stb.inv4    = invMode[4];
    stb.mulLate = vld[4] & invMode[4];
    stb.scaleY0 = invMode[4] & finFlag[4];
  end

  assign outValid = vld[PIPE_DEPTH];

  // cycles since reset, saturating at the pipeline depth
  logic [WARM_W-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != WARM_W'(PIPE_DEPTH)) warm <= warm + 1'b1;
  end

  logic modeClash;
  always_comb begin
    modeClash = 1'b0;
    for (int k = 1; k < PIPE_DEPTH; k++) begin
      if (vld[k] && (invMode[k] != inMode)) modeClash = 1'b1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (warm != WARM_W'(PIPE_DEPTH)) |-> !outValid);

  a_r2_valid_after_five: assert property (@(posedge clk) disable iff (rst)
    ((warm == WARM_W'(PIPE_DEPTH)) && $past(inValid, 5)) |-> outValid);

  a_r10_no_result_without_input: assert property (@(posedge clk) disable iff (rst)
    ((warm == WARM_W'(PIPE_DEPTH)) && !$past(inValid, 5)) |-> !outValid);

  // R11: the shared twiddle bank needs one direction in flight at a time
  a_r11_mode_steady: assert property (@(posedge clk) disable iff (rst)
    inValid |-> !modeClash);

endmodule

// File: rtl/rad4_datapath.sv
module rad4_datapath
  import rad4_pkg::*;
(
  input  logic    clk,
  input  strobe_t stb,
  input  quad_t   inCoef,
  input  twid_t   inTw,
  output quad_t   outCoef
);

  quad_t r1, r2, r3, r4, r5;
  twid_t t1, t2, t3, t4;
  quad_t n1, n2, n3, n4, n5;

  // shared twiddle multiplier bank: inputs in forward, stage 4 in inverse
  twid_t mulA, mulB, mulP;

  genvar g;
  for (g = 0; g < TWIDS; g++) begin : gBank
    assign mulA[g] = stb.mulLate ? r4[g+1] : inCoef[g+1];
    assign mulB[g] = stb.mulLate ? t4[g]   : inTw[g];
    rad4_modmul uTwMul (.opA(mulA[g]), .opB(mulB[g]), .prod(mulP[g]));
  end

  // stage 1: forward lanes 1..3 take their twiddle products
  always_comb begin
    n1[0] = inCoef[0];
    for (int k = 1; k < LANES; k++) begin
      n1[k] = stb.inv0 ? inCoef[k] : mulP[k-1];
    end
  end

  // stage 2: first add/subtract layer, pairing depends on direction
  coef_t pairX, pairY, pairZ, pairW;
  always_comb begin
    pairX = r1[0];
    pairY = stb.inv1 ? r1[1] : r1[2];
    pairZ = stb.inv1 ? r1[2] : r1[1];
    pairW = r1[3];
    n2[0] = modAdd(pairX, pairY);
    n2[1] = modSub(pairX, pairY);
    n2[2] = modAdd(pairZ, pairW);
    n2[3] = modSub(pairZ, pairW);
  end

  // stage 3: quarter-root constant multiplier on the odd difference
  coef_t quarterK, quarterP;
  assign quarterK = stb.inv2 ? COEF_W'(QUARTER_INV) : COEF_W'(QUARTER_ROOT);
  rad4_modmul uQuarter (.opA(r2[3]), .opB(quarterK), .prod(quarterP));

  always_comb begin
    n3    = r2;
    n3[3] = quarterP;
  end

  // stage 4: second add/subtract layer, output routing depends on direction
  coef_t sumA, difB, sumC, difD;
  always_comb begin
    sumA  = modAdd(r3[0], r3[2]);
    difB  = modSub(r3[0], r3[2]);
    sumC  = modAdd(r3[1], r3[3]);
    difD  = modSub(r3[1], r3[3]);
    n4[0] = sumA;
    n4[1] = stb.inv3 ? sumC : difB;
    n4[2] = stb.inv3 ? difB : sumC;
    n4[3] = difD;
  end

  // stage 5: inverse twiddles and the single 1/128 multiplier on lane 0
  coef_t scaleP;
  rad4_modmul uScale (.opA(r4[0]), .opB(COEF_W'(INV_SCALE)), .prod(scaleP));

  always_comb begin
    n5[0] = stb.scaleY0 ? scaleP : r4[0];
    for (int k = 1; k < LANES; k++) begin
      n5[k] = stb.inv4 ? mulP[k-1] : r4[k];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.load[0]) begin r1 <= n1; t1 <= inTw; end
    if (stb.load[1]) begin r2 <= n2; t2 <= t1;   end
    if (stb.load[2]) begin r3 <= n3; t3 <= t2;   end
    if (stb.load[3]) begin r4 <= n4; t4 <= t3;   end
    if (stb.load[4]) r5 <= n5;
  end

  assign outCoef = r5;

endmodule

// File: rtl/rad4_butterfly.sv
module rad4_butterfly
  import rad4_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           inValid,
  input  logic                           inMode,
  input  logic                           inFinal,
  input  logic [LANES-1:0][COEF_W-1:0]   inCoef,
  input  logic [TWIDS-1:0][COEF_W-1:0]   inTw,
  output logic                           outValid,
  output logic [LANES-1:0][COEF_W-1:0]   outCoef
);

  strobe_t stb;

  rad4_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inMode   (inMode),
    .inFinal  (inFinal),
    .stb      (stb),
    .outValid (outValid)
  );

  rad4_datapath uData (
    .clk     (clk),
    .stb     (stb),
    .inCoef  (inCoef),
    .inTw    (inTw),
    .outCoef (outCoef)
  );

  logic outInRange;
  always_comb begin
    outInRange = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (outCoef[k] >= COEF_W'(MODQ)) outInRange = 1'b0;
    end
  end

  a_r9_out_reduced: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outInRange);

endmodule

// File: tb/rad4_butterfly_tb_top.sv
`timescale 1ns/1ps
module rad4_butterfly_tb_top;

  localparam int Q  = 3329;
  localparam int JF = 1729;
  localparam int JI = 1600;
  localparam int SC = 3303;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, inValid, inMode, inFinal;
  logic [3:0][11:0] inCoef;
  logic [2:0][11:0] inTw;
  logic outValid;
  logic [3:0][11:0] outCoef;

  rad4_butterfly dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode), .inFinal(inFinal),
    .inCoef(inCoef), .inTw(inTw), .outValid(outValid), .outCoef(outCoef)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0][11:0] expData [0:1023];
  int               expDue  [0:1023];
  string            expTag  [0:1023];
  int wrPtr = 0;
  int rdPtr = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference arithmetic
  function automatic int mq(input int a, input int b); return (a * b) % Q; endfunction
  function automatic int aq(input int a, input int b); return (a + b) % Q; endfunction
  function automatic int sq(input int a, input int b); return (a - b + Q) % Q; endfunction

  function automatic logic [3:0][11:0] pack4(input int y0, input int y1, input int y2, input int y3);
    return {12'(y3), 12'(y2), 12'(y1), 12'(y0)};
  endfunction

  function automatic logic [3:0][11:0] fwdDirect(input logic [3:0][11:0] c, input logic [2:0][11:0] w);
    int p1, p2, p3, s, d, t, e;
    p1 = mq(int'(c[1]), int'(w[0]));
    p2 = mq(int'(c[2]), int'(w[1]));
    p3 = mq(int'(c[3]), int'(w[2]));
    s = aq(int'(c[0]), p2); d = sq(int'(c[0]), p2);
    t = aq(p1, p3);         e = mq(sq(p1, p3), JF);
    return pack4(aq(s, t), sq(s, t), aq(d, e), sq(d, e));
  endfunction

  function automatic logic [3:0][11:0] invDirect(input logic [3:0][11:0] c, input logic [2:0][11:0] w);
    int s, d, t, e;
    s = aq(int'(c[0]), int'(c[1])); d = sq(int'(c[0]), int'(c[1]));
    t = aq(int'(c[2]), int'(c[3])); e = mq(sq(int'(c[2]), int'(c[3])), JI);
    return pack4(aq(s, t), mq(aq(d, e), int'(w[0])), mq(sq(s, t), int'(w[1])), mq(sq(d, e), int'(w[2])));
  endfunction

  function automatic logic [3:0][11:0] fwdCascade(input logic [3:0][11:0] c, input int w0, input int w1);
    int b0, b1, b2, b3, u, v, w1j;
    u  = mq(w0, int'(c[2])); v = mq(w0, int'(c[3]));
    b0 = aq(int'(c[0]), u);  b2 = sq(int'(c[0]), u);
    b1 = aq(int'(c[1]), v);  b3 = sq(int'(c[1]), v);
    w1j = mq(w1, JF);
    return pack4(aq(b0, mq(w1, b1)), sq(b0, mq(w1, b1)), aq(b2, mq(w1j, b3)), sq(b2, mq(w1j, b3)));
  endfunction

  function automatic logic [3:0][11:0] invCascade(input logic [3:0][11:0] c, input int v0, input int v1);
    int b0, b1, b2, b3;
    b0 = aq(int'(c[0]), int'(c[1]));
    b1 = mq(sq(int'(c[0]), int'(c[1])), v1);
    b2 = aq(int'(c[2]), int'(c[3]));
    b3 = mq(sq(int'(c[2]), int'(c[3])), mq(v1, JI));
    return pack4(aq(b0, b2), aq(b1, b3), mq(sq(b0, b2), v0), mq(sq(b1, b3), v0));
  endfunction

  function automatic logic [11:0] rq();
    return 12'($urandom_range(0, Q - 1));
  endfunction

  function automatic logic [3:0][11:0] randQuad();
    return {rq(), rq(), rq(), rq()};
  endfunction

  function automatic logic [2:0][11:0] twSet(input int w0, input int w1);
    return {12'(mq(w0, w1)), 12'(w0), 12'(w1)};
  endfunction

  // output monitor: data, latency, and no unexpected results
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (rdPtr >= wrPtr) begin
        check(1'b0, "R10", "unexpected result", 48'(outCoef), 48'h0);
      end else begin
        check(outCoef == expData[rdPtr], expTag[rdPtr], "result", 48'(outCoef), 48'(expData[rdPtr]));
        check(cyc == expDue[rdPtr], "R2", "latency cycle", 48'(cyc), 48'(expDue[rdPtr]));
        rdPtr++;
      end
    end
  end

  task automatic issue(input logic mode, input logic fin, input logic [3:0][11:0] c,
                       input logic [2:0][11:0] tw, input logic [3:0][11:0] exp, input string tag);
    @(negedge clk);
    inValid = 1'b1; inMode = mode; inFinal = fin; inCoef = c; inTw = tw;
    expData[wrPtr] = exp;
    expDue[wrPtr]  = cyc + 5;
    expTag[wrPtr]  = tag;
    wrPtr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inFinal = 1'($urandom_range(0, 1));
      inCoef = randQuad(); inTw = {rq(), rq(), rq()};
    end
  endtask

  task automatic drain(input string tag);
    idle(8);
    check(rdPtr == wrPtr, tag, "results delivered", 48'(rdPtr), 48'(wrPtr));
  endtask

  task automatic testReset();
    rst = 1'b1; inValid = 1'b1; inMode = 1'b0; inFinal = 1'b0;
    inCoef = randQuad(); inTw = {rq(), rq(), rq()};
    repeat (4) @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1", "outValid after reset", 48'(outValid), 48'h0);
    end
  endtask

  task automatic testFwdCascade();
    for (int i = 0; i < 24; i++) begin
      logic [3:0][11:0] c;
      int w0, w1;
      c = randQuad(); w0 = int'(rq()); w1 = int'(rq());
      issue(1'b0, 1'b0, c, twSet(w0, w1), fwdCascade(c, w0, w1), "R5");
    end
    drain("R5");
  endtask

  task automatic testInvCascade();
    for (int i = 0; i < 24; i++) begin
      logic [3:0][11:0] c;
      int v0, v1;
      c = randQuad(); v0 = int'(rq()); v1 = int'(rq());
      issue(1'b1, 1'b0, c, twSet(v0, v1), invCascade(c, v0, v1), "R6");
    end
    drain("R6");
  endtask

  task automatic testDirect(input logic mode);
    for (int i = 0; i < 16; i++) begin
      logic [3:0][11:0] c;
      logic [2:0][11:0] w;
      c = randQuad(); w = {rq(), rq(), rq()};
      if (mode) issue(1'b1, 1'b0, c, w, invDirect(c, w), "R4");
      else      issue(1'b0, 1'b0, c, w, fwdDirect(c, w), "R3");
    end
    drain(mode ? "R4" : "R3");
  endtask

  task automatic testBoundary();
    logic [3:0][11:0] cMax, cZero, cMix, cOne;
    logic [2:0][11:0] wMax, wOne;
    cMax = {4{12'd3328}}; cZero = '0; cOne = {12'd0, 12'd0, 12'd0, 12'd1};
    cMix = {12'd0, 12'd3328, 12'd0, 12'd3328};
    wMax = {3{12'd3328}}; wOne = {3{12'd1}};
    issue(1'b0, 1'b0, cMax,  wMax, fwdDirect(cMax, wMax),  "R9");
    issue(1'b0, 1'b0, cZero, wMax, fwdDirect(cZero, wMax), "R9");
    issue(1'b0, 1'b0, cOne,  wOne, pack4(1, 1, 1, 1),      "R9");
    issue(1'b0, 1'b0, cMix,  wMax, fwdDirect(cMix, wMax),  "R9");
    drain("R9");
    issue(1'b1, 1'b0, cMax,  wMax, invDirect(cMax, wMax),  "R9");
    issue(1'b1, 1'b0, cMix,  wMax, invDirect(cMix, wMax),  "R9");
    issue(1'b1, 1'b0, cZero, wOne, pack4(0, 0, 0, 0),      "R9");
    drain("R9");
  endtask

  task automatic testFinalInverse();
    for (int i = 0; i < 12; i++) begin
      logic [3:0][11:0] c, plain;
      logic [2:0][11:0] w, wPre;
      c = randQuad(); w = {rq(), rq(), rq()};
      for (int k = 0; k < 3; k++) wPre[k] = 12'(mq(int'(w[k]), SC));
      plain = invDirect(c, w);
      issue(1'b1, 1'b1, c, wPre,
            pack4(mq(int'(plain[0]), SC), mq(int'(plain[1]), SC),
                  mq(int'(plain[2]), SC), mq(int'(plain[3]), SC)), "R7");
    end
    drain("R7");
  endtask

  task automatic testFinalForward();
    for (int i = 0; i < 8; i++) begin
      logic [3:0][11:0] c;
      logic [2:0][11:0] w;
      c = randQuad(); w = {rq(), rq(), rq()};
      issue(1'b0, 1'b1, c, w, fwdDirect(c, w), "R8");
    end
    drain("R8");
  endtask

  task automatic testGaps();
    for (int i = 0; i < 16; i++) begin
      logic [3:0][11:0] c;
      logic [2:0][11:0] w;
      c = randQuad(); w = {rq(), rq(), rq()};
      issue(1'b1, 1'b0, c, w, invDirect(c, w), "R10");
      idle(1 + (i % 3));
    end
    drain("R10");
  endtask

  task automatic testModeSwitch();
    for (int r = 0; r < 4; r++) begin
      logic mode;
      mode = 1'(r % 2);
      for (int i = 0; i < 5; i++) begin
        logic [3:0][11:0] c;
        logic [2:0][11:0] w;
        c = randQuad(); w = {rq(), rq(), rq()};
        issue(mode, 1'b0, c, w, mode ? invDirect(c, w) : fwdDirect(c, w), "R11");
      end
      drain("R11");
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testFwdCascade();
    testInvCascade();
    testDirect(1'b0);
    testDirect(1'b1);
    testBoundary();
    testFinalInverse();
    testFinalForward();
    testGaps();
    testModeSwitch();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule